// File: doc/BRIEF.md
# Partitioned SIMD Integer Adder

This block adds two 64-bit operands on one byte-sliced carry chain that can be cut into independent lanes. A 3-bit control travels with every operation: a lane-parallel flag and a 2-bit element-size code. With the flag set, the word is split into eight, four, two or one lanes, and each lane is summed on its own. No carry passes from one lane into the next. With the flag clear, only the lowest element of the selected size is summed, and every result bit above it reads zero. The operands carry no mode information. The mode comes only from the control given with the operation.

The control field does not drive the adder directly. A registered decode stage first turns it into per-byte controls: carry-kill at each lane boundary, a result byte-enable and a carry-out enable. The add result is registered in the following cycle. The result therefore appears two clock cycles after an operation is presented, with a valid flag that travels alongside. A new operation can be accepted on every cycle.

Top module: `psimd_add`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, out_valid is 0 and out_sum and out_cout are 0.
- R2: out_valid is 1 exactly two rising clock edges after a cycle with in_valid = 1, and is 0 otherwise. Operations issued on back-to-back cycles produce results on back-to-back cycles, in the same order.
- R3: With in_simd = 1 and size code 00 (8-bit elements), each byte k of out_sum equals (a byte k + b byte k) mod 256, with no carry between bytes.
- R4: With in_simd = 1, size code 01 gives four independent 16-bit lane sums, and size code 10 gives two independent 32-bit lane sums.
- R5: Size code 11 (64-bit elements) gives the full 64-bit modular sum whatever the value of in_simd, and out_cout bit 7 is the carry out of bit 63.
- R6: With in_simd = 0 and size code 00, 01 or 10, the low 8, 16 or 32 bits of out_sum hold the low-element sum, and all bits above that element are 0.
- R7: out_cout bit j carries the carry out of the lane whose top byte is byte j, for every active lane. Every other bit of out_cout is 0. In scalar mode the only active lane is the lowest element.
- R8: The size code is read as 00 = 8-bit, 01 = 16-bit, 10 = 32-bit and 11 = 64-bit elements.
- R9: While out_valid is 0, out_sum and out_cout keep the values of the last result, whatever the operands and control presented with in_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The operation on the inputs is taken this cycle |
| in_simd | input | 1 | 1 = all lanes, 0 = lowest element only |
| in_size | input | 2 | Element-size code (see R8) |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | out_sum and out_cout hold a new result |
| out_sum | output | 64 | Lane-partitioned sum |
| out_cout | output | 8 | Per-byte carry out, set only at the top byte of each active lane |

## Verification
A wrong carry-kill bit in the decode register shows up as a one-unit error at the low end of the next lane. A wrong byte-enable shows up as a stray nonzero byte above a scalar element. Either fault is visible in out_sum two cycles after the operation is presented. A misplaced carry-out enable appears as a set bit of out_cout in a non-top position, or as a missing carry, in that same cycle. The corner operands (all ones plus one, and 0x80 patterns) push a carry against every boundary, so each of these faults is exposed by the first affected operation rather than left to chance.

// File: rtl/psimd_add.sv
module psimd_add #(
  parameter int LANE_W = 8,
  parameter int LANES  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_simd,
  input  logic [1:0]              in_size,
  input  logic [LANE_W*LANES-1:0] in_a,
  input  logic [LANE_W*LANES-1:0] in_b,
  output logic                    out_valid,
  output logic [LANE_W*LANES-1:0] out_sum,
  output logic [LANES-1:0]        out_cout
);
  localparam int W  = LANE_W * LANES;
  localparam int IW = $clog2(LANES);

  logic [IW-1:0]  low_bits;
  logic [LANES-1:0] kill_d, ben_d, cen_d;

  assign low_bits = IW'((4'd1 << in_size) - 4'd1);

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic [IW-1:0] idx;
      idx       = IW'(i);
      kill_d[i] = (idx & low_bits) == '0;
      ben_d[i]  = in_simd || ((idx & ~low_bits) == '0);
      cen_d[i]  = ((idx & low_bits) == low_bits) && (in_simd || idx == low_bits);
    end
  end

  logic             v1;
  logic [W-1:0]     a1, b1;
  logic [LANES-1:0] kill1, ben1, cen1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      a1    <= '0;
      b1    <= '0;
      kill1 <= '0;
      ben1  <= '0;
      cen1  <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        a1    <= in_a;
        b1    <= in_b;
        kill1 <= kill_d;
        ben1  <= ben_d;
        cen1  <= cen_d;
      end
    end
  end

  logic [LANES:0]   carry;
  logic [W-1:0]     sum_c;
  logic [LANES-1:0] cout_c;

  assign carry[0] = 1'b0;

  for (genvar g = 0; g < LANES; g++) begin : g_slice
    logic [LANE_W:0] part;
    assign part = {1'b0, a1[g*LANE_W +: LANE_W]} + {1'b0, b1[g*LANE_W +: LANE_W]}
                + {{LANE_W{1'b0}}, carry[g] & ~kill1[g]};
    assign carry[g+1]              = part[LANE_W];
    assign sum_c[g*LANE_W +: LANE_W] = part[LANE_W-1:0] & {LANE_W{ben1[g]}};
    assign cout_c[g]               = part[LANE_W] & cen1[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_cout  <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        out_sum  <= sum_c;
        out_cout <= cout_c;
      end
    end
  end
endmodule

module psimd_add_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_simd,
  input logic [1:0]  in_size,
  input logic        out_valid,
  input logic [63:0] out_sum,
  input logic [7:0]  out_cout
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  function automatic logic [7:0] top_bytes(input logic simd, input logic [1:0] sz);
    logic [7:0] m;
    int eb;
    eb = 1 << sz;
    m = '0;
    for (int k = 0; k < 8; k++)
      if ((k + 1) % eb == 0 && (simd || k + 1 == eb)) m[k] = 1'b1;
    return m;
  endfunction

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |-> (!out_valid && out_sum == '0 && out_cout == '0));

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R7
  cout_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && out_valid) |-> ((out_cout & ~top_bytes($past(in_simd, 2), $past(in_size, 2))) == '0));

  // R6
  scalar_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && out_valid && !$past(in_simd, 2) && $past(in_size, 2) != 2'd3)
    |-> ((out_sum >> (8 << $past(in_size, 2))) == '0));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && !out_valid) |-> ($stable(out_sum) && $stable(out_cout)));
endmodule

bind psimd_add psimd_add_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_simd(in_simd),
  .in_size(in_size), .out_valid(out_valid), .out_sum(out_sum), .out_cout(out_cout)
);

// File: tb/psimd_add_bench.sv
`timescale 1ns/1ps
module psimd_add_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_simd = 1'b0;
  logic [1:0]  in_size = 2'd0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [63:0] out_sum;
  logic [7:0]  out_cout;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  psimd_add u_psimd_add (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_simd(in_simd), .in_size(in_size),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_sum(out_sum), .out_cout(out_cout)
  );

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model(input bit simd, input logic [1:0] sz, input logic [63:0] a, input logic [63:0] b,
                       output logic [63:0] s, output logic [7:0] c);
    int w, n;
    logic [63:0] m, la, lb;
    logic [64:0] t;
    w = 8 << sz;
    n = simd ? 64 / w : 1;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    s = '0;
    c = '0;
    for (int k = 0; k < n; k++) begin
      la = (a >> (k * w)) & m;
      lb = (b >> (k * w)) & m;
      t = {1'b0, la} + {1'b0, lb};
      s = s | ((t[63:0] & m) << (k * w));
      c[(k * w + w) / 8 - 1] = (w == 64) ? t[64] : t[w];
    end
  endtask

  function automatic string tag(input bit simd, input logic [1:0] sz);
    if (sz == 2'd3) return "R5/R8";
    if (!simd) return "R6/R8";
    if (sz == 2'd0) return "R3/R8";
    return "R4/R8";
  endfunction

  task automatic one_op(input bit simd, input logic [1:0] sz, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] es;
    logic [7:0]  ec;
    model(simd, sz, a, b, es, ec);
    @(negedge clk);
    in_valid = 1'b1; in_simd = simd; in_size = sz; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0; in_simd = ~simd; in_size = ~sz; in_a = ~a; in_b = {$urandom, $urandom};
    @(negedge clk);
    chk64("R2", {63'd0, out_valid}, 64'd1);
    chk64(tag(simd, sz), out_sum, es);
    chk64("R7", {56'd0, out_cout}, {56'd0, ec});
    @(negedge clk);
    chk64("R2", {63'd0, out_valid}, 64'd0);
    chk64("R9", out_sum, es);
    chk64("R9", {56'd0, out_cout}, {56'd0, ec});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] corner_a[5], corner_b[5];
    corner_a[0] = '1;                    corner_b[0] = 64'd1;
    corner_a[1] = 64'h7f7f_7f7f_7f7f_7f7f; corner_b[1] = 64'h0101_0101_0101_0101;
    corner_a[2] = 64'h8080_8080_8080_8080; corner_b[2] = 64'h8080_8080_8080_8080;
    corner_a[3] = 64'hffff_0000_ffff_00ff; corner_b[3] = 64'h0001_ffff_0001_0001;
    corner_a[4] = 64'h0;                  corner_b[4] = 64'h0;

    // R1: during and just after reset
    #3;
    chk64("R1", {55'd0, out_valid, out_cout}, 64'd0);
    chk64("R1", out_sum, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk64("R1", {55'd0, out_valid, out_cout}, 64'd0);
    chk64("R1", out_sum, 64'd0);

    for (int md = 0; md < 2; md++)
      for (int sz = 0; sz < 4; sz++) begin
        for (int k = 0; k < 5; k++) one_op(bit'(md), 2'(sz), corner_a[k], corner_b[k]);
        for (int k = 0; k < 20; k++) one_op(bit'(md), 2'(sz), {$urandom, $urandom}, {$urandom, $urandom});
      end

    // R2: back-to-back ops stream in order
    begin
      logic [63:0] xa[4], xb[4], es;
      logic [7:0] ec;
      for (int k = 0; k < 4; k++) begin xa[k] = {$urandom, $urandom}; xb[k] = {$urandom, $urandom}; end
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        in_valid = 1'b1; in_simd = 1'b1; in_size = 2'(k); in_a = xa[k]; in_b = xb[k];
        if (k >= 2) begin
          model(1'b1, 2'(k - 2), xa[k-2], xb[k-2], es, ec);
          chk64("R2", {63'd0, out_valid}, 64'd1);
          chk64("R2", out_sum, es);
        end
        @(negedge clk);
      end
      in_valid = 1'b0;
      for (int k = 2; k < 4; k++) begin
        model(1'b1, 2'(k), xa[k], xb[k], es, ec);
        chk64("R2", {63'd0, out_valid}, 64'd1);
        chk64("R2", out_sum, es);
        @(negedge clk);
      end
      chk64("R2", {63'd0, out_valid}, 64'd0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule